// File: doc/BRIEF.md
# Unified TLB Address-Array Write Engine

This block applies bus writes aimed at the address half of a unified translation buffer (the UTLB). It holds the UTLB address words and the small instruction TLB (ITLB) address words in registers of its own. It also keeps the round-robin replacement counter that sits in a slot of the MMU control word. Each address word carries a 22-bit virtual page number, a dirty flag, a valid flag and an 8-bit address-space identifier.

A write takes one of two paths, chosen by one bit of the bus address. A direct write stores the data word into the UTLB slot that the address names. This finishes in one cycle and never raises busy. An associative write looks for entries whose page number and identifier equal those in the data word. It walks the UTLB one slot per cycle and then resolves the ITLB in one further cycle. It can raise a multiple-hit exception request and a page-flush request. The ITLB is loaded from outside through a fill port that the refill path drives.

Top module: `utlb_array_writer`

## Requirements
- R1: The write data word is decoded as page number in bits 31:10, dirty flag in bit 9, valid flag in bit 8 and identifier in bits 7:0. Address bit 7 set selects an associative write. Address bit 7 clear selects a direct write, with address bits 13:8 naming the UTLB slot.
- R2: A direct write accepted while idle replaces the whole address word of the named slot at the next clock edge. Busy stays low throughout.
- R3: The replacement counter sits in bits 15:10 of the control word output. It advances once for every UTLB slot the write touches: one for a direct write, and one for each slot visited by an associative scan. An advance that yields 63, or yields the bound held in control-word input bits 23:18, produces 0 instead.
- R4: Every control-word output bit outside 15:10 equals the matching input bit.
- R5: An associative write raises busy from the next cycle and visits slots 0 upward, one per cycle. Each valid slot with an equal page number and equal identifier takes the new dirty and valid flags. All other slots keep their contents.
- R6: When a second valid UTLB slot matches, the scan stops at that slot. That slot is left unchanged and the counter does not advance for it. For exactly one cycle exc_req is high, with exc_code 0x140. The fault address output then holds the full bus address of the write.
- R7: After the UTLB scan, the lowest ITLB slot with equal page number and identifier (its valid flag is ignored for this test) is updated. If a UTLB slot matched, it takes a copy of that slot's updated word. Otherwise only its valid flag changes.
- R8: After an associative write, a one-cycle flush request carries the written page number if any matching UTLB or ITLB entry went from valid to invalid.
- R9: A direct write over a valid UTLB word that has no bit-identical copy in the ITLB gives a one-cycle flush request carrying the old page number. If such a copy exists, no flush is requested.
- R10: A write presented while busy is high is ignored.
- R11: After reset, all UTLB and ITLB words are zero, the counter is zero, and busy, exc_req and flush_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write to the address array |
| wr_addr | input | 32 | Bus write address |
| wr_data | input | 32 | Bus write data word |
| mmucr_i | input | 32 | Current MMU control word (bound in 23:18) |
| itlb_fill_en | input | 1 | ITLB load from the refill path |
| itlb_fill_idx | input | 2 | ITLB slot being loaded |
| itlb_fill_word | input | 32 | Address word being loaded into the ITLB |
| busy | output | 1 | Associative write in progress |
| mmucr_o | output | 32 | Control word with the counter slot updated |
| utlb_flat | output | 2048 | All UTLB words, slot k at bits 32k+31:32k |
| itlb_flat | output | 128 | All ITLB words, slot k at bits 32k+31:32k |
| exc_req | output | 1 | Multiple-hit exception request pulse |
| exc_code | output | 12 | Exception code, 0x140 while exc_req is high |
| tea | output | 32 | Address of the write that faulted |
| flush_req | output | 1 | Page flush request pulse |
| flush_vpn | output | 22 | Page number to flush |

## Verification
The hardest state to reach is a UTLB holding two valid slots with the same page number and identifier. Only then does the stop-on-second-match path with its exception pulse run. The stimulus builds this state with two direct writes of one word to different slots, plus an invalid third copy placed further along. It then issues an associative write for that key, so the scan stops early with a precise counter value. The counter bound is reached by reading back the counter through the control-word output and then programming the bound two steps ahead.

// File: rtl/utlbw_pkg.sv
package utlbw_pkg;
    localparam int VPN_W     = 22;
    localparam int ASID_W    = 8;
    localparam int MODE_BIT  = 7;
    localparam int IDX_LSB   = 8;
    localparam int URC_LSB   = 10;
    localparam int URB_LSB   = 18;
    localparam logic [11:0] MULTI_HIT_CODE = 12'h140;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic              dirty;
        logic              valid;
        logic [ASID_W-1:0] asid;
    } tlb_word_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_ITLB = 2'd2
    } phase_e;
endpackage

// File: rtl/utlbw_urc_step.sv
module utlbw_urc_step #(
    parameter int W    = 6,
    parameter int LAST = 63
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] bound,
    output logic [W-1:0] nxt
);
    logic [W-1:0] inc;

    assign inc = cur + W'(1);

    always_comb begin
        if (inc == bound || inc == W'(LAST)) nxt = '0;
        else                                 nxt = inc;
    end
endmodule

// File: rtl/utlbw_itlb_probe.sv
module utlbw_itlb_probe
    import utlbw_pkg::*;
#(
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  tlb_word_t [N-1:0]  tlb,
    input  logic [VPN_W-1:0]   key_vpn,
    input  logic [ASID_W-1:0]  key_asid,
    input  tlb_word_t          probe,
    output logic               hit,
    output logic [IW-1:0]      hit_idx,
    output logic               copy_exists
);
    logic [N-1:0] key_m;
    logic [N-1:0] same_m;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign key_m[g]  = (tlb[g].vpn == key_vpn) && (tlb[g].asid == key_asid);
        assign same_m[g] = (tlb[g] == probe);
    end

    always_comb begin
        hit         = |key_m;
        copy_exists = |same_m;
        hit_idx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (key_m[i]) hit_idx = IW'(i);
        end
    end
endmodule

// File: rtl/utlb_array_writer.sv
module utlb_array_writer
    import utlbw_pkg::*;
#(
    parameter  int UTLB_N = 64,
    parameter  int ITLB_N = 4,
    localparam int UIW    = $clog2(UTLB_N),
    localparam int IIW    = $clog2(ITLB_N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [31:0]           wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [31:0]           mmucr_i,
    input  logic                  itlb_fill_en,
    input  logic [IIW-1:0]        itlb_fill_idx,
    input  logic [31:0]           itlb_fill_word,
    output logic                  busy,
    output logic [31:0]           mmucr_o,
    output logic [UTLB_N*32-1:0]  utlb_flat,
    output logic [ITLB_N*32-1:0]  itlb_flat,
    output logic                  exc_req,
    output logic [11:0]           exc_code,
    output logic [31:0]           tea,
    output logic                  flush_req,
    output logic [VPN_W-1:0]      flush_vpn
);
    typedef struct packed {
        phase_e                   ph;
        logic [UIW-1:0]           idx;
        logic                     hit;
        logic [UIW-1:0]           hit_idx;
        logic                     nf;
        logic [31:0]              addr;
        tlb_word_t                wd;
        logic [UIW-1:0]           urc;
        tlb_word_t [UTLB_N-1:0]   utlb;
        tlb_word_t [ITLB_N-1:0]   itlb;
        logic                     exc;
        logic [11:0]              code;
        logic [31:0]              tea;
        logic                     flush;
        logic [VPN_W-1:0]         fvpn;
    } state_t;

    state_t st_d, st_q;

    tlb_word_t       in_word;
    tlb_word_t       scan_word;
    tlb_word_t       old_word;
    logic [UIW-1:0]  didx;
    logic [UIW-1:0]  urb;
    logic [UIW-1:0]  urc_nxt;
    logic            scan_hit;
    logic            i_hit;
    logic [IIW-1:0]  i_idx;
    logic            i_copy;

    assign in_word   = tlb_word_t'(wr_data);
    assign didx      = wr_addr[IDX_LSB +: UIW];
    assign urb       = mmucr_i[URB_LSB +: UIW];
    assign scan_word = st_q.utlb[st_q.idx];
    assign old_word  = st_q.utlb[didx];
    assign scan_hit  = scan_word.valid
                    && (scan_word.vpn  == st_q.wd.vpn)
                    && (scan_word.asid == st_q.wd.asid);

    utlbw_urc_step #(
        .W    (UIW),
        .LAST (UTLB_N - 1)
    ) u_urc (
        .cur   (st_q.urc),
        .bound (urb),
        .nxt   (urc_nxt)
    );

    utlbw_itlb_probe #(
        .N (ITLB_N)
    ) u_probe (
        .tlb         (st_q.itlb),
        .key_vpn     (st_q.wd.vpn),
        .key_asid    (st_q.wd.asid),
        .probe       (old_word),
        .hit         (i_hit),
        .hit_idx     (i_idx),
        .copy_exists (i_copy)
    );

    always_comb begin
        st_d       = st_q;
        st_d.exc   = 1'b0;
        st_d.code  = '0;
        st_d.flush = 1'b0;

        if (itlb_fill_en) st_d.itlb[itlb_fill_idx] = tlb_word_t'(itlb_fill_word);

        unique case (st_q.ph)
            PH_IDLE: begin
                if (wr_en) begin
                    if (wr_addr[MODE_BIT]) begin
                        st_d.ph      = PH_SCAN;
                        st_d.idx     = '0;
                        st_d.hit     = 1'b0;
                        st_d.hit_idx = '0;
                        st_d.nf      = 1'b0;
                        st_d.addr    = wr_addr;
                        st_d.wd      = in_word;
                    end else begin
                        if (old_word.valid && !i_copy) begin
                            st_d.flush = 1'b1;
                            st_d.fvpn  = old_word.vpn;
                        end
                        st_d.utlb[didx] = in_word;
                        st_d.urc        = urc_nxt;
                    end
                end
            end
            PH_SCAN: begin
                if (scan_hit && st_q.hit) begin
                    st_d.exc  = 1'b1;
                    st_d.code = MULTI_HIT_CODE;
                    st_d.tea  = st_q.addr;
                    st_d.ph   = PH_ITLB;
                end else begin
                    if (scan_hit) begin
                        if (!st_q.wd.valid) st_d.nf = 1'b1;
                        st_d.utlb[st_q.idx].valid = st_q.wd.valid;
                        st_d.utlb[st_q.idx].dirty = st_q.wd.dirty;
                        st_d.hit     = 1'b1;
                        st_d.hit_idx = st_q.idx;
                    end
                    st_d.urc = urc_nxt;
                    if (st_q.idx == UIW'(UTLB_N - 1)) st_d.ph  = PH_ITLB;
                    else                              st_d.idx = st_q.idx + UIW'(1);
                end
            end
            PH_ITLB: begin
                if (i_hit) begin
                    if (st_q.itlb[i_idx].valid && !st_q.wd.valid) st_d.nf = 1'b1;
                    if (st_q.hit) st_d.itlb[i_idx]       = st_q.utlb[st_q.hit_idx];
                    else          st_d.itlb[i_idx].valid = st_q.wd.valid;
                end
                if (st_d.nf) begin
                    st_d.flush = 1'b1;
                    st_d.fvpn  = st_q.wd.vpn;
                end
                st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        mmucr_o                   = mmucr_i;
        mmucr_o[URC_LSB +: UIW]   = st_q.urc;
    end

    assign busy      = (st_q.ph != PH_IDLE);
    assign utlb_flat = st_q.utlb;
    assign itlb_flat = st_q.itlb;
    assign exc_req   = st_q.exc;
    assign exc_code  = st_q.code;
    assign tea       = st_q.tea;
    assign flush_req = st_q.flush;
    assign flush_vpn = st_q.fvpn;
endmodule

// File: rtl/utlb_array_writer_chk.sv
module utlb_array_writer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_addr,
    input logic        busy,
    input logic        exc_req,
    input logic [11:0] exc_code,
    input logic [31:0] mmucr_o
);
    logic [5:0] urc;
    assign urc = mmucr_o[15:10];

    // R6
    exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req);

    // R6
    exc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (exc_code == 12'h140 && busy));

    // R2
    direct_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && !wr_addr[7]) |=> !busy);

    // R5
    assoc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_addr[7]) |=> busy);

    // R3
    urc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urc != $past(urc)) |-> (urc == $past(urc) + 6'd1 || urc == 6'd0));
endmodule

bind utlb_array_writer utlb_array_writer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .busy     (busy),
    .exc_req  (exc_req),
    .exc_code (exc_code),
    .mmucr_o  (mmucr_o)
);

// File: tb/utlb_array_writer_bench.sv
module utlb_array_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int UN = 64;
    localparam int IN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] mmucr_i = 32'hA500_0003;
    logic        fill_en = 1'b0;
    logic [1:0]  fill_idx = '0;
    logic [31:0] fill_word = '0;
    logic        busy;
    logic [31:0] mmucr_o;
    logic [UN*32-1:0] utlb_flat;
    logic [IN*32-1:0] itlb_flat;
    logic        exc_req;
    logic [11:0] exc_code;
    logic [31:0] tea;
    logic        flush_req;
    logic [21:0] flush_vpn;

    int nchk = 0;
    int nbad = 0;
    int nflush = 0;
    int nexc = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    utlb_array_writer u_utlb_array_writer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mmucr_i(mmucr_i), .itlb_fill_en(fill_en), .itlb_fill_idx(fill_idx),
        .itlb_fill_word(fill_word), .busy(busy), .mmucr_o(mmucr_o),
        .utlb_flat(utlb_flat), .itlb_flat(itlb_flat), .exc_req(exc_req),
        .exc_code(exc_code), .tea(tea), .flush_req(flush_req), .flush_vpn(flush_vpn)
    );

    // reference model state
    logic [31:0] mu [UN];
    logic [31:0] mi [IN];
    int mph, midx, mhit, mhidx, mnf, murc, mk, mj, mfound;
    logic [31:0] maddr, mwd, me, mtea;
    logic mexc, mflush;
    logic [21:0] mfvpn;

    function automatic int nurc(int c, int b);
        int x;
        x = (c + 1) % 64;
        if (x == b || x == 63) return 0;
        return x;
    endfunction

    function automatic logic [31:0] mkw(logic [21:0] vpn, logic d, logic v, logic [7:0] asid);
        return {vpn, d, v, asid};
    endfunction

    function automatic logic [31:0] uw(int k);
        return utlb_flat[k*32 +: 32];
    endfunction

    function automatic logic [31:0] iw(int k);
        return itlb_flat[k*32 +: 32];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        mexc = 1'b0;
        mflush = 1'b0;
        if (!rst_n) begin
            for (int k = 0; k < UN; k++) mu[k] = '0;
            for (int k = 0; k < IN; k++) mi[k] = '0;
            mph = 0; midx = 0; mhit = 0; mhidx = 0; mnf = 0; murc = 0;
            maddr = '0; mwd = '0; mtea = '0; mfvpn = '0;
        end else begin
            case (mph)
                0: if (wr_en) begin
                    if (wr_addr[7]) begin
                        mph = 1; midx = 0; mhit = 0; mnf = 0; maddr = wr_addr; mwd = wr_data;
                    end else begin
                        mk = int'(wr_addr[13:8]);
                        if (mu[mk][8]) begin
                            mfound = 0;
                            for (int j = 0; j < IN; j++) if (mi[j] == mu[mk]) mfound = 1;
                            if (mfound == 0) begin mflush = 1'b1; mfvpn = mu[mk][31:10]; end
                        end
                        mu[mk] = wr_data;
                        murc = nurc(murc, int'(mmucr_i[23:18]));
                    end
                end
                1: begin
                    me = mu[midx];
                    if (me[8] && me[31:10] == mwd[31:10] && me[7:0] == mwd[7:0] && mhit != 0) begin
                        mexc = 1'b1; mtea = maddr; mph = 2;
                    end else begin
                        if (me[8] && me[31:10] == mwd[31:10] && me[7:0] == mwd[7:0]) begin
                            if (!mwd[8]) mnf = 1;
                            mu[midx][9:8] = mwd[9:8];
                            mhit = 1; mhidx = midx;
                        end
                        murc = nurc(murc, int'(mmucr_i[23:18]));
                        if (midx == UN - 1) mph = 2; else midx++;
                    end
                end
                default: begin
                    mj = -1;
                    for (int j = IN - 1; j >= 0; j--)
                        if (mi[j][31:10] == mwd[31:10] && mi[j][7:0] == mwd[7:0]) mj = j;
                    if (mj >= 0) begin
                        if (mi[mj][8] && !mwd[8]) mnf = 1;
                        if (mhit != 0) mi[mj] = mu[mhidx];
                        else mi[mj][8] = mwd[8];
                    end
                    if (mnf != 0) begin mflush = 1'b1; mfvpn = mwd[31:10]; end
                    mph = 0;
                end
            endcase
            if (fill_en) mi[fill_idx] = fill_word;
        end
    end

    always @(posedge clk) begin : compare
        #3;
        if (cmp_on) begin
            int bad;
            chk(busy === (mph != 0), "R5 R10 busy", 64'(busy), 64'(mph != 0));
            chk(mmucr_o === {mmucr_i[31:16], 6'(murc), mmucr_i[9:0]}, "R3 R4 control word",
                64'(mmucr_o), 64'({mmucr_i[31:16], 6'(murc), mmucr_i[9:0]}));
            bad = -1;
            for (int k = UN - 1; k >= 0; k--) if (uw(k) !== mu[k]) bad = k;
            if (bad >= 0) chk(1'b0, "R1 R2 R5 R6 utlb word", 64'(uw(bad)), 64'(mu[bad]));
            else chk(1'b1, "R5 utlb", 0, 0);
            bad = -1;
            for (int k = IN - 1; k >= 0; k--) if (iw(k) !== mi[k]) bad = k;
            if (bad >= 0) chk(1'b0, "R7 itlb word", 64'(iw(bad)), 64'(mi[bad]));
            else chk(1'b1, "R7 itlb", 0, 0);
            chk(exc_req === mexc, "R6 exc_req", 64'(exc_req), 64'(mexc));
            chk(exc_code === (mexc ? 12'h140 : 12'h0), "R6 exc_code", 64'(exc_code), 64'(mexc ? 12'h140 : 12'h0));
            chk(tea === mtea, "R6 tea", 64'(tea), 64'(mtea));
            chk(flush_req === mflush, "R8 R9 flush_req", 64'(flush_req), 64'(mflush));
            chk(flush_vpn === mfvpn, "R8 R9 flush_vpn", 64'(flush_vpn), 64'(mfvpn));
            if (flush_req) nflush++;
            if (exc_req) nexc++;
        end
    end

    task automatic dwrite(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 32'hF600_0000 | (idx << 8); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic awrite(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 32'hF600_0080; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic ifill(input int idx, input logic [31:0] d);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = 2'(idx); fill_word = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            nbad++; nchk++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin : stim
        int f0, cur;
        logic [5:0] ub;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy === 1'b0 && exc_req === 1'b0 && flush_req === 1'b0, "R11 reset flags", 64'({busy, exc_req, flush_req}), 0);
        chk(utlb_flat === '0 && itlb_flat === '0, "R11 reset arrays", 64'(uw(0)), 0);
        chk(mmucr_o[15:10] === 6'd0, "R11 reset counter", 64'(mmucr_o[15:10]), 0);

        dwrite(3,  mkw(22'h1000, 1'b0, 1'b1, 8'h11));
        dwrite(10, mkw(22'h1000, 1'b0, 1'b1, 8'h11));
        dwrite(20, mkw(22'h1000, 1'b0, 1'b0, 8'h11));
        dwrite(5,  mkw(22'h2000, 1'b1, 1'b1, 8'h22));
        dwrite(6,  mkw(22'h3000, 1'b0, 1'b1, 8'h33));
        // R1 field decode and slot index
        chk(uw(5) === mkw(22'h2000, 1'b1, 1'b1, 8'h22), "R1 direct slot 5", 64'(uw(5)), 64'(mkw(22'h2000, 1'b1, 1'b1, 8'h22)));
        chk(mmucr_o[15:10] === 6'd5, "R3 five direct advances", 64'(mmucr_o[15:10]), 5);

        ifill(0, mkw(22'h2000, 1'b1, 1'b1, 8'h22));
        ifill(1, mkw(22'h3000, 1'b0, 1'b1, 8'h33));
        ifill(2, mkw(22'h4000, 1'b0, 1'b1, 8'h44));
        ifill(3, mkw(22'h1000, 1'b1, 1'b1, 8'h11));

        // R8 valid to invalid through associative write
        f0 = nflush;
        awrite(mkw(22'h3000, 1'b1, 1'b0, 8'h33));
        chk(nflush == f0 + 1, "R8 assoc invalidate flush", 64'(nflush - f0), 1);
        chk(iw(1) === mkw(22'h3000, 1'b1, 1'b0, 8'h33), "R7 itlb copy of utlb", 64'(iw(1)), 64'(mkw(22'h3000, 1'b1, 1'b0, 8'h33)));

        // R6 duplicate valid entries
        awrite(mkw(22'h1000, 1'b1, 1'b1, 8'h11));
        chk(nexc == 1, "R6 one exception pulse", 64'(nexc), 1);
        chk(tea === 32'hF600_0080, "R6 fault address", 64'(tea), 64'(32'hF600_0080));
        chk(uw(10) === mkw(22'h1000, 1'b0, 1'b1, 8'h11), "R6 second match untouched", 64'(uw(10)), 64'(mkw(22'h1000, 1'b0, 1'b1, 8'h11)));
        chk(uw(3) === mkw(22'h1000, 1'b1, 1'b1, 8'h11), "R5 first match updated", 64'(uw(3)), 64'(mkw(22'h1000, 1'b1, 1'b1, 8'h11)));

        // R7 no UTLB match: ITLB valid only
        f0 = nflush;
        awrite(mkw(22'h4000, 1'b1, 1'b0, 8'h44));
        chk(iw(2) === mkw(22'h4000, 1'b0, 1'b0, 8'h44), "R7 valid flag only", 64'(iw(2)), 64'(mkw(22'h4000, 1'b0, 1'b0, 8'h44)));
        chk(nflush == f0 + 1, "R8 itlb invalidate flush", 64'(nflush - f0), 1);

        // identifier mismatch: nothing changes
        awrite(mkw(22'h2000, 1'b0, 1'b0, 8'h99));
        chk(uw(5) === mkw(22'h2000, 1'b1, 1'b1, 8'h22), "R5 identifier mismatch kept", 64'(uw(5)), 64'(mkw(22'h2000, 1'b1, 1'b1, 8'h22)));

        // R10 direct write while busy
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 32'hF600_0080; wr_data = mkw(22'h7777, 1'b0, 1'b1, 8'h01);
        @(negedge clk);
        wr_addr = 32'hF600_2800; wr_data = mkw(22'h5555, 1'b1, 1'b1, 8'h55);
        @(negedge clk);
        wr_en = 1'b0;
        while (busy) @(negedge clk);
        chk(uw(40) === 32'h0, "R10 write while busy ignored", 64'(uw(40)), 0);

        // R9 direct overwrite: identical ITLB copy vs none
        f0 = nflush;
        dwrite(5, mkw(22'h2100, 1'b0, 1'b1, 8'h22));
        chk(nflush == f0, "R9 copy present no flush", 64'(nflush - f0), 0);
        dwrite(10, mkw(22'h2200, 1'b0, 1'b1, 8'h22));
        chk(nflush == f0 + 1 && flush_vpn === 22'h1000, "R9 flush old page", 64'(flush_vpn), 64'(22'h1000));

        // R3 bound wrap
        while (mmucr_o[15:10] >= 6'd60) dwrite(7, 32'h0);
        cur = int'(mmucr_o[15:10]);
        ub = 6'(cur + 2);
        @(negedge clk);
        mmucr_i = {8'hC3, ub, 18'h2_5A5A};
        dwrite(8, 32'h0);
        dwrite(9, 32'h0);
        chk(mmucr_o[15:10] === 6'd0, "R3 bound wrap", 64'(mmucr_o[15:10]), 0);
        // R4 other bits follow input
        chk({mmucr_o[31:16], mmucr_o[9:0]} === {mmucr_i[31:16], mmucr_i[9:0]}, "R4 passthrough",
            64'({mmucr_o[31:16], mmucr_o[9:0]}), 64'({mmucr_i[31:16], mmucr_i[9:0]}));

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule